// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides when a multi-port cable physical layer may drop into its low-power state and when it must come back out. It watches a status summary of every port and the link-side control lines. When the link interface has been switched off and no port is doing useful work, it turns off the PLL and the switchable part of the reference circuitry. It also reports when the deepest sleep level is allowed. A wake request (the link powering back up, or a port event the node has to answer) turns the PLL back on. The block then counts a fixed lock interval before it declares the clock usable.

A separate powerdown pin overrides everything. While it is high, the sequencer holds its own state in reset, raises an internal reset for the surrounding logic and turns every switchable resource off. The cable-bias status output stays live, because software uses it to choose when to power the device up or down. That output has no filtering.

Top module: `lpm_sequencer`

## Requirements
- R1: `noCableBias` is 1 in the same cycle in which no bit of `biasDetect` is set, and 0 otherwise. It follows the inputs directly with no filtering, including while `pdPin` is high.
- R2: While `pdPin` is 1, `logicReset` is 1 and `pllEnable`, `refEnable`, `deepSleep` and `clockReady` are 0. After `pdPin` falls, the block goes through the full wake sequence of R9.
- R3: In the running state, if at a rising edge `ifaceDisabled` is 1, every port is inactive and no wake event is present, then `pllEnable` and `refEnable` are 0 from that edge on. A port is inactive when its `portConnected` bit is 0, its `portDisabled` bit is 1, or its `portSuspended` bit is 1.
- R4: The low-power state is not entered while `ifaceDisabled` is 0. It is also not entered while any port is connected, not disabled and not suspended.
- R5: `deepSleep` is 1 only in the low-power state, and only while `portIntEn` is 0 and every port is either not connected or disabled. A connected port that is merely suspended keeps it at 0.
- R6: In the low-power state, `linkPowerOn` = 1 at a rising edge turns `pllEnable` and `refEnable` back on from that edge. In the running state, `linkPowerOn` = 1 blocks entry.
- R7: For a suspended port, a set `biasDetect` bit or a clear `connectDetect` bit is a wake event.
- R8: For a port whose `portDisabled` bit is 0, `connectDetect` = 1 while `portConnected` = 0 is a wake event. The same pattern on a disabled port has no effect.
- R9: `clockReady` rises exactly `LOCK_CYCLES` rising edges after the edge that started the wake, and `pllEnable` stays 1 for the whole interval. `LOCK_CYCLES` must be chosen so that this interval fits within 3 ms of the clock.
- R10: While waking, the entry conditions of R3 are ignored. Low power can be re-entered only at the edge after `clockReady` has risen.
- R11: After `rst_n` is released, the block starts in the waking state, with `pllEnable` = 1 and `clockReady` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pdPin | input | 1 | Powerdown request; holds the block in reset |
| portConnected | input | NUM_PORTS | Port state: connected |
| portDisabled | input | NUM_PORTS | Port state: disabled |
| portSuspended | input | NUM_PORTS | Port state: suspended |
| biasDetect | input | NUM_PORTS | Incoming bias seen on each port |
| connectDetect | input | NUM_PORTS | Raw cable presence on each port |
| portIntEn | input | 1 | Port event interrupt enable |
| ifaceDisabled | input | 1 | Link interface has been switched off |
| linkPowerOn | input | 1 | Link power status |
| pllEnable | output | 1 | PLL enable |
| refEnable | output | 1 | Switchable reference circuitry enable |
| deepSleep | output | 1 | Deepest sleep level permitted |
| noCableBias | output | 1 | No port sees incoming bias |
| logicReset | output | 1 | Reset for the internal logic |
| clockReady | output | 1 | Clock locked and link interface usable |

## Verification
`noCableBias`, `logicReset` and the powerdown gating are combinational, so they are due in the cycle the input changes. Entry to and exit from low power are due at the first rising edge that sees the condition. `clockReady` is due `LOCK_CYCLES` edges after that wake edge. The bench changes inputs on the falling edge and compares every output two nanoseconds later against a behavioural model. The model advances its mode and lock countdown on each rising edge, so each result is checked in the very cycle it falls due and in every cycle after it.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    ST_WAKE = 2'd0,
    ST_RUN  = 2'd1,
    ST_LOW  = 2'd2
  } lpm_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClear;
    logic cntStep;
  } lpm_strobe_t;

  // condition summary from datapath to control
  typedef struct packed {
    logic allInactive;
    logic deepOk;
    logic wakeEvent;
    logic lockDone;
  } lpm_status_t;

endpackage

// File: rtl/lpm_datapath.sv
module lpm_datapath
  import lpm_pkg::*;
#(
  parameter int NUM_PORTS   = 2,
  parameter int LOCK_CYCLES = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pdPin,
  input  logic [NUM_PORTS-1:0] portConnected,
  input  logic [NUM_PORTS-1:0] portDisabled,
  input  logic [NUM_PORTS-1:0] portSuspended,
  input  logic [NUM_PORTS-1:0] biasDetect,
  input  logic [NUM_PORTS-1:0] connectDetect,
  input  logic                 portIntEn,
  input  logic                 linkPowerOn,
  input  lpm_strobe_t          strobe,
  output lpm_status_t          status,
  output logic                 noCableBias
);

  localparam int CNT_W = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOCK_CYCLES - 1);

  logic [NUM_PORTS-1:0] portIdle;
  logic [NUM_PORTS-1:0] portQuiet;
  logic [NUM_PORTS-1:0] portEvent;
  logic [CNT_W-1:0]     lockCnt;

  // per-port classification
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic suspWake;
    logic attachWake;
    assign portIdle[p]  = ~portConnected[p] | portDisabled[p] | portSuspended[p];
    assign portQuiet[p] = ~portConnected[p] | portDisabled[p];
    assign suspWake     = portSuspended[p] & (biasDetect[p] | ~connectDetect[p]);
    assign attachWake   = ~portDisabled[p] & connectDetect[p] & ~portConnected[p];
    assign portEvent[p] = suspWake | attachWake;
  end

  // PLL lock wait counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lockCnt <= '0;
    end else if (pdPin || strobe.cntClear) begin
      lockCnt <= '0;
    end else if (strobe.cntStep && lockCnt != CNT_LAST) begin
      lockCnt <= lockCnt + 1'b1;
    end
  end

  always_comb begin
    status.allInactive = &portIdle;
    status.deepOk      = (&portQuiet) & ~portIntEn;
    status.wakeEvent   = linkPowerOn | (|portEvent);
    status.lockDone    = (lockCnt == CNT_LAST);
  end

  assign noCableBias = ~(|biasDetect);

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pdPin,
  input  logic        ifaceDisabled,
  input  lpm_status_t status,
  output lpm_strobe_t strobe,
  output logic        pllEnable,
  output logic        refEnable,
  output logic        deepSleep,
  output logic        clockReady,
  output logic        logicReset
);

  lpm_state_e state;
  lpm_state_e stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_WAKE: if (status.lockDone) stateNext = ST_RUN;
      ST_RUN:  if (ifaceDisabled && status.allInactive && !status.wakeEvent)
                 stateNext = ST_LOW;
      ST_LOW:  if (status.wakeEvent) stateNext = ST_WAKE;
      default: stateNext = ST_WAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_WAKE;
    end else if (pdPin) begin
      state <= ST_WAKE;
    end else begin
      state <= stateNext;
    end
  end

  always_comb begin
    strobe.cntStep  = (state == ST_WAKE);
    strobe.cntClear = (state != ST_WAKE);
  end

  always_comb begin
    logicReset = pdPin | ~rst_n;
    pllEnable  = ~pdPin & (state != ST_LOW);
    refEnable  = ~pdPin & (state != ST_LOW);
    clockReady = ~pdPin & (state == ST_RUN);
    deepSleep  = ~pdPin & (state == ST_LOW) & status.deepOk;
  end

endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_pkg::*;
#(
  parameter int NUM_PORTS   = 2,
  parameter int LOCK_CYCLES = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pdPin,
  input  logic [NUM_PORTS-1:0] portConnected,
  input  logic [NUM_PORTS-1:0] portDisabled,
  input  logic [NUM_PORTS-1:0] portSuspended,
  input  logic [NUM_PORTS-1:0] biasDetect,
  input  logic [NUM_PORTS-1:0] connectDetect,
  input  logic                 portIntEn,
  input  logic                 ifaceDisabled,
  input  logic                 linkPowerOn,
  output logic                 pllEnable,
  output logic                 refEnable,
  output logic                 deepSleep,
  output logic                 noCableBias,
  output logic                 logicReset,
  output logic                 clockReady
);

  lpm_strobe_t strobe;
  lpm_status_t status;

  lpm_datapath #(
    .NUM_PORTS  (NUM_PORTS),
    .LOCK_CYCLES(LOCK_CYCLES)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .pdPin        (pdPin),
    .portConnected(portConnected),
    .portDisabled (portDisabled),
    .portSuspended(portSuspended),
    .biasDetect   (biasDetect),
    .connectDetect(connectDetect),
    .portIntEn    (portIntEn),
    .linkPowerOn  (linkPowerOn),
    .strobe       (strobe),
    .status       (status),
    .noCableBias  (noCableBias)
  );

  lpm_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .pdPin        (pdPin),
    .ifaceDisabled(ifaceDisabled),
    .status       (status),
    .strobe       (strobe),
    .pllEnable    (pllEnable),
    .refEnable    (refEnable),
    .deepSleep    (deepSleep),
    .clockReady   (clockReady),
    .logicReset   (logicReset)
  );

endmodule

// File: rtl/lpm_sequencer_checker.sv
module lpm_sequencer_checker #(
  parameter int NUM_PORTS   = 2,
  parameter int LOCK_CYCLES = 64
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 pdPin,
  input logic [NUM_PORTS-1:0] portConnected,
  input logic [NUM_PORTS-1:0] portDisabled,
  input logic [NUM_PORTS-1:0] portSuspended,
  input logic [NUM_PORTS-1:0] biasDetect,
  input logic [NUM_PORTS-1:0] connectDetect,
  input logic                 portIntEn,
  input logic                 ifaceDisabled,
  input logic                 linkPowerOn,
  input logic                 pllEnable,
  input logic                 refEnable,
  input logic                 deepSleep,
  input logic                 noCableBias,
  input logic                 logicReset,
  input logic                 clockReady
);

  logic idleAll;
  logic anyWake;
  int   waitCnt;

  always_comb begin
    idleAll = 1'b1;
    anyWake = linkPowerOn;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (portConnected[p] && !portDisabled[p] && !portSuspended[p]) idleAll = 1'b0;
      if (portSuspended[p] && (biasDetect[p] || !connectDetect[p])) anyWake = 1'b1;
      if (!portDisabled[p] && connectDetect[p] && !portConnected[p]) anyWake = 1'b1;
    end
  end

  // length of the current lock wait, bounded by a counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) waitCnt <= 0;
    else if (pdPin || clockReady || !pllEnable) waitCnt <= 0;
    else waitCnt <= waitCnt + 1;
  end

  assert_pd_gates_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pdPin |-> (logicReset && !pllEnable && !refEnable && !clockReady && !deepSleep));

  assert_enter_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clockReady && ifaceDisabled && idleAll && !anyWake && !pdPin) |=> (!pllEnable || pdPin));

  assert_entry_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pllEnable) && !pdPin) |-> $past(ifaceDisabled && idleAll));

  assert_deep_only_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    deepSleep |-> (!portIntEn && !pllEnable));

  assert_link_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pllEnable && linkPowerOn && !pdPin) |=> (pllEnable || pdPin));

  assert_lock_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    waitCnt <= LOCK_CYCLES);

  assert_ready_needs_pll_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clockReady) |-> $past(pllEnable));

  assert_bias_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (biasDetect != '0) |-> !noCableBias);

endmodule

bind lpm_sequencer lpm_sequencer_checker #(
  .NUM_PORTS  (NUM_PORTS),
  .LOCK_CYCLES(LOCK_CYCLES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pdPin        (pdPin),
  .portConnected(portConnected),
  .portDisabled (portDisabled),
  .portSuspended(portSuspended),
  .biasDetect   (biasDetect),
  .connectDetect(connectDetect),
  .portIntEn    (portIntEn),
  .ifaceDisabled(ifaceDisabled),
  .linkPowerOn  (linkPowerOn),
  .pllEnable    (pllEnable),
  .refEnable    (refEnable),
  .deepSleep    (deepSleep),
  .noCableBias  (noCableBias),
  .logicReset   (logicReset),
  .clockReady   (clockReady)
);

// File: tb/sim_lpm_sequencer.sv
module sim_lpm_sequencer;

  localparam int NP   = 2;
  localparam int LOCK = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pdPin = 1'b0;
  logic [NP-1:0] pConn = '0, pDis = '0, pSusp = '0, pBias = '0, pDet = '0;
  logic          intEn = 1'b0, iface = 1'b0, lps = 1'b0;
  logic          pllEnable, refEnable, deepSleep, noCableBias, logicReset, clockReady;

  int    checks = 0;
  int    errors = 0;
  string curReq = "R11";
  bit    done = 1'b0;

  // model: 0 waking, 1 running, 2 low power
  int mode = 0;
  int lockLeft = LOCK;

  always #4 clk = ~clk;

  lpm_sequencer #(.NUM_PORTS(NP), .LOCK_CYCLES(LOCK)) u0 (
    .clk(clk), .rst_n(rst_n), .pdPin(pdPin),
    .portConnected(pConn), .portDisabled(pDis), .portSuspended(pSusp),
    .biasDetect(pBias), .connectDetect(pDet), .portIntEn(intEn),
    .ifaceDisabled(iface), .linkPowerOn(lps),
    .pllEnable(pllEnable), .refEnable(refEnable), .deepSleep(deepSleep),
    .noCableBias(noCableBias), .logicReset(logicReset), .clockReady(clockReady)
  );

  function automatic bit modelAllIdle();
    for (int i = 0; i < NP; i++)
      if (pConn[i] && !pDis[i] && !pSusp[i]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit modelWake();
    if (lps) return 1'b1;
    for (int i = 0; i < NP; i++) begin
      if (pSusp[i] && (pBias[i] || !pDet[i])) return 1'b1;
      if (!pDis[i] && pDet[i] && !pConn[i]) return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic bit modelDeep();
    if (intEn) return 1'b0;
    for (int i = 0; i < NP; i++)
      if (pConn[i] && !pDis[i]) return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || pdPin) begin
      mode = 0;
      lockLeft = LOCK;
    end else begin
      case (mode)
        0: begin
          lockLeft = lockLeft - 1;
          if (lockLeft == 0) mode = 1;
        end
        1: if (iface && modelAllIdle() && !modelWake()) mode = 2;
        default: if (modelWake()) begin
          mode = 0;
          lockLeft = LOCK;
        end
      endcase
    end
  end

  // compare every cycle, away from the edges
  always @(negedge clk) begin
    logic [5:0] got, exp;
    #2;
    exp[5] = !pdPin && mode != 2;
    exp[4] = !pdPin && mode != 2;
    exp[3] = !pdPin && mode == 2 && modelDeep();
    exp[2] = (pBias == '0);
    exp[1] = pdPin || !rst_n;
    exp[0] = !pdPin && mode == 1;
    got = {pllEnable, refEnable, deepSleep, noCableBias, logicReset, clockReady};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b (pll,ref,deep,nobias,rst,ready) at %0t",
               curReq, got, exp, $time);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R11: reset state then wake sequence
    idle(3);
    rst_n = 1'b1;
    idle(LOCK + 3);

    // R1: bias flag follows inputs with no delay, running state
    curReq = "R1";
    pConn = 2'b11; pDet = 2'b11;
    pBias = 2'b01; idle(2);
    pBias = 2'b10; idle(2);
    pBias = 2'b11; idle(2);
    pBias = 2'b00; idle(2);

    // R4: no entry with an active port, nor with the interface enabled
    curReq = "R4";
    iface = 1'b1; idle(4);
    iface = 1'b0; pConn = 2'b00; pDet = 2'b00; idle(4);

    // R3 / R5: entry, deep sleep allowed
    curReq = "R3";
    iface = 1'b1; idle(4);
    curReq = "R5";
    intEn = 1'b1; idle(2);
    intEn = 1'b0; pConn = 2'b01; pSusp = 2'b01; pDet = 2'b01; idle(2);
    pSusp = 2'b00; pDis = 2'b01; idle(2);

    // R8: attach on disabled port ignored, on enabled port wakes
    curReq = "R8";
    pConn = 2'b00; idle(2);
    pDet = 2'b11; idle(1);
    // R10: entry conditions hold during the lock wait
    curReq = "R10";
    pDet = 2'b01; idle(LOCK + 4);

    // R7: suspended port, bias and then disconnect
    curReq = "R7";
    pConn = 2'b01; pDis = 2'b00; pSusp = 2'b01; pDet = 2'b01; idle(2);
    pBias = 2'b01; idle(1);
    pBias = 2'b00; idle(LOCK + 4);
    pDet = 2'b00; idle(4);
    pConn = 2'b00; pSusp = 2'b00; idle(LOCK + 4);

    // R6: link power status wakes and blocks entry
    curReq = "R6";
    lps = 1'b1; idle(LOCK + 4);
    lps = 1'b0; idle(4);

    // R2: powerdown override and recovery
    curReq = "R2";
    pBias = 2'b10; pdPin = 1'b1; idle(4);
    pBias = 2'b00; idle(2);
    pdPin = 1'b0;
    curReq = "R9";
    idle(LOCK + 4);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule